// File: doc/BRIEF.md
# Blanking-Line Ancillary Packet Builder

This block turns the two or four raw bytes recovered from one vertical-blanking video line into a complete 10-bit ancillary data packet. The packet can then be inserted into a digital video stream. A one-cycle `start` strobe captures the raw bytes together with the packet attributes:

- the byte count;
- a double-rate flag;
- an even-field flag;
- a 4-bit source line code;
- a mode bit that chooses between sending each byte whole or splitting it into two nibble words.

The block then streams the packet one word per transfer. The order is: three flag words, the identification word, a secondary identification word, a data-count word, the user data words, any padding, and finally a checksum.

The output is a valid/ready stream. `out_valid` stays high from the cycle after an accepted start until the checksum word is transferred. A word transfers on a rising edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the block holds `out_word` unchanged and does not advance. The block has no input buffer, so a `start` that arrives while a packet is in flight is dropped. `done` pulses for one cycle right after the checksum word has transferred.

Top module: `anc_pkt_fmt`

## Requirements
- R1: After reset, `out_valid` and `done` are low, and no word is produced until an accepted `start`.
- R2: Every packet begins with the words 0x000, 0x3FF, 0x3FF and then the identification word 0x140.
- R3: The fifth word carries the even-field flag in bit 7, the double-rate flag in bit 6, the line code in bits 5:2, and zeros in bits 1:0. Bit 8 makes the number of ones in bits 8:0 even, and bit 9 is the inverse of bit 8.
- R4: The sixth word carries the data count (user word count divided by 4) in bits 3:2 and zeros in bits 7:4 and 1:0, with the same parity rule as R3. The data count is 2 for four bytes in nibble mode and 1 in every other case.
- R5: In byte mode (`split_nib`=0), each raw byte goes out as one word with the byte in bits 9:2 and bits 1:0 zero. Bytes go out in order from `raw_bytes[7:0]` upward.
- R6: In nibble mode (`split_nib`=1), each byte becomes two words: the low nibble first, then the high nibble. Each nibble is zero-extended into bits 9:2.
- R7: Two bytes in byte mode are followed by two padding words of value 0x200, so that the user word count is 4. No other case has padding.
- R8: The last word is the checksum: bits 8:2 hold the sum, modulo 128, of bits 8:2 of the identification, secondary identification, data-count and all user words (padding included). Bits 1:0 are zero and bit 9 is the inverse of bit 8.
- R9: While `out_valid` is high and `out_ready` is low, `out_word` and `out_valid` hold on the next cycle.
- R10: A `start` that arrives while `out_valid` is high is ignored and does not alter the packet being sent.
- R11: `done` is high for exactly one cycle, in the cycle after the checksum word transfers.
- R12: A `start` that arrives in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and begin a packet when idle |
| raw_bytes | input | 32 | Raw bytes; byte 0 in bits 7:0 |
| four_bytes | input | 1 | 1 = four raw bytes, 0 = two |
| dbl_rate | input | 1 | Double-rate format flag |
| even_fld | input | 1 | Line came from an even field |
| line_code | input | 4 | Source line identifier |
| split_nib | input | 1 | 1 = nibble words, 0 = whole-byte words |
| out_ready | input | 1 | Downstream can take a word |
| out_valid | output | 1 | `out_word` is valid |
| out_word | output | 10 | Packet word |
| done | output | 1 | One-cycle pulse after the checksum transfers |

## Verification
The two functions that can coincide are the end of one packet and the start of the next. The `done` pulse and the idle state that accepts a new `start` fall in the same cycle. The bench waits for `done` and drives `start` in that same cycle. It then expects the second packet to follow the first with no lost or repeated words, and it expects `done` to appear once per packet. A `start` driven one cycle earlier, while the checksum is still in flight, must be dropped. This is judged by the queue draining exactly with no extra words.

// File: rtl/anc_pkg.sv
package anc_pkg;
  localparam int WORD_W = 10;
  localparam int BYTE_W = 8;
  localparam int SUM_W  = 7;
  localparam int HDR_N  = 6;

  localparam logic [WORD_W-1:0] FLAG0_W = 10'h000;
  localparam logic [WORD_W-1:0] FLAG1_W = 10'h3FF;
  localparam logic [WORD_W-1:0] ID_W    = 10'h140;
  localparam logic [WORD_W-1:0] PAD_W   = 10'h200;

  // Even parity over bits 8:0, inverted copy in bit 9
  function automatic logic [WORD_W-1:0] prot_word(input logic [BYTE_W-1:0] p);
    logic par;
    par = ^p;
    return {~par, par, p};
  endfunction
endpackage

// File: rtl/anc_udw_sel.sv
module anc_udw_sel
  import anc_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic [NB*BYTE_W-1:0] raw,
  input  logic                 four,
  input  logic                 split,
  input  logic [2:0]           k,
  output logic [WORD_W-1:0]    udw
);
  localparam int IW = $clog2(NB);

  logic [BYTE_W-1:0] b [NB];
  for (genvar g = 0; g < NB; g++) begin : g_slice
    assign b[g] = raw[g*BYTE_W +: BYTE_W];
  end

  logic [IW-1:0] nib_idx;
  logic [IW-1:0] byte_idx;
  logic [3:0]    nib;
  logic [2:0]    nbytes;

  always_comb begin
    nbytes   = four ? 3'd4 : 3'd2;
    nib_idx  = IW'(k >> 1);
    byte_idx = IW'(k);
    nib      = k[0] ? b[nib_idx][7:4] : b[nib_idx][3:0];
    if (split)
      udw = {4'b0000, nib, 2'b00};
    else if (k < nbytes)
      udw = {b[byte_idx], 2'b00};
    else
      udw = PAD_W;
  end
endmodule

// File: rtl/anc_cksum.sv
module anc_cksum
  import anc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [SUM_W-1:0]  sum
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (en)  sum <= sum + din[8:2];
  end
endmodule

// File: rtl/anc_pkt_fmt.sv
module anc_pkt_fmt
  import anc_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [31:0]        raw_bytes,
  input  logic               four_bytes,
  input  logic               dbl_rate,
  input  logic               even_fld,
  input  logic [3:0]         line_code,
  input  logic               split_nib,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_word,
  output logic               done
);
  localparam int MAX_UDW = 2 * NB;
  localparam int IDX_W   = $clog2(HDR_N + MAX_UDW + 1);

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [31:0]       raw_q;
  logic              four_q, split_q, ef_q, dbl_q;
  logic [3:0]        line_q;
  logic [IDX_W-1:0]  last_idx;
  logic [1:0]        dc;
  logic [WORD_W-1:0] udw;
  logic [SUM_W-1:0]  sum;
  logic [2:0]        k;
  logic              accept, take;

  assign take   = start & ~busy;
  assign accept = busy & out_ready;

  always_comb begin
    if (split_q && four_q) begin
      last_idx = IDX_W'(HDR_N + 8);
      dc       = 2'd2;
    end else begin
      last_idx = IDX_W'(HDR_N + 4);
      dc       = 2'd1;
    end
  end

  assign k = 3'(idx - IDX_W'(HDR_N));

  anc_udw_sel #(.NB(NB)) u_sel (
    .raw   (raw_q[NB*BYTE_W-1:0]),
    .four  (four_q),
    .split (split_q),
    .k     (k),
    .udw   (udw)
  );

  anc_cksum u_ck (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (take),
    .en    (accept && idx >= IDX_W'(3) && idx != last_idx),
    .din   (out_word),
    .sum   (sum)
  );

  always_comb begin
    case (idx)
      IDX_W'(0): out_word = FLAG0_W;
      IDX_W'(1),
      IDX_W'(2): out_word = FLAG1_W;
      IDX_W'(3): out_word = ID_W;
      IDX_W'(4): out_word = prot_word({ef_q, dbl_q, line_q, 2'b00});
      IDX_W'(5): out_word = prot_word({4'b0000, dc, 2'b00});
      default:   out_word = (idx == last_idx) ? {~sum[6], sum, 2'b00} : udw;
    endcase
  end

  assign out_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      done    <= 1'b0;
      raw_q   <= '0;
      four_q  <= 1'b0;
      split_q <= 1'b0;
      ef_q    <= 1'b0;
      dbl_q   <= 1'b0;
      line_q  <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        busy    <= 1'b1;
        idx     <= '0;
        raw_q   <= raw_bytes;
        four_q  <= four_bytes;
        split_q <= split_nib;
        ef_q    <= even_fld;
        dbl_q   <= dbl_rate;
        line_q  <= line_code;
      end else if (accept) begin
        if (idx == last_idx) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/anc_pkt_fmt_chk.sv
module anc_pkt_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       out_ready,
  input logic       out_valid,
  input logic [9:0] out_word,
  input logic       done,
  input logic [3:0] idx,
  input logic [3:0] last_idx,
  input logic [31:0] raw_q
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && idx == last_idx |=> done && !out_valid); // R11

  AST_HDR_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (idx == 4'd4 || idx == 4'd5) |->
      (^out_word[8:0]) == 1'b0 && out_word[9] != out_word[8]); // R3

  AST_CS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && idx == last_idx |->
      out_word[1:0] == 2'b00 && out_word[9] != out_word[8]); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && start && !(out_ready && idx == last_idx) |=> $stable(raw_q)); // R10

  AST_FLAG_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_word == 10'h000); // R2
endmodule

bind anc_pkt_fmt anc_pkt_fmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_word  (out_word),
  .done      (done),
  .idx       (idx),
  .last_idx  (last_idx),
  .raw_q     (raw_q)
);

// File: tb/sim_anc_pkt_fmt.sv
module sim_anc_pkt_fmt;
  typedef struct {
    logic [9:0] w;
    bit         last;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [31:0] raw_bytes = '0;
  logic       four_bytes = 1'b0, dbl_rate = 1'b0, even_fld = 1'b0, split_nib = 1'b0;
  logic [3:0] line_code = '0;
  logic       out_ready = 1'b1;
  logic       out_valid, done;
  logic [9:0] out_word;

  item_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'h5B;
  bit prev_last = 0, prev_stall = 0;
  logic [9:0] prev_word = '0;

  always #5 clk = ~clk;

  anc_pkt_fmt u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .raw_bytes(raw_bytes),
    .four_bytes(four_bytes), .dbl_rate(dbl_rate), .even_fld(even_fld),
    .line_code(line_code), .split_nib(split_nib), .out_ready(out_ready),
    .out_valid(out_valid), .out_word(out_word), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] pw(input logic [7:0] p);
    return {~(^p), ^p, p};
  endfunction

  // ready pattern, changed away from edges
  always begin
    @(posedge clk); #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (prev_stall)
      chk(out_valid && out_word == prev_word, "R9 hold", out_word, prev_word);
    if (done || prev_last)
      chk(done == prev_last, "R11 done", {9'b0, done}, {9'b0, prev_last});
    prev_last  = 0;
    prev_stall = out_valid && !out_ready;
    prev_word  = out_word;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected word", out_word, 10'h3FF);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(out_word == it.w, it.tag, out_word, it.w);
        prev_last = it.last;
      end
    end
  end

  task automatic push(input logic [9:0] w, input string tag, input bit last = 0);
    item_t it;
    it.w = w; it.tag = tag; it.last = last;
    exp_q.push_back(it);
  endtask

  task automatic build(input logic [31:0] raw, input bit four, input bit split,
                       input bit ef, input bit dbl, input logic [3:0] ln);
    logic [9:0] u[$];
    logic [6:0] s;
    logic [9:0] sd, dcw;
    int nb;
    nb  = four ? 4 : 2;
    sd  = pw({ef, dbl, ln, 2'b00});
    dcw = pw({4'b0, (split && four) ? 2'd2 : 2'd1, 2'b00});
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b;
      b = raw[i*8 +: 8];
      if (split) begin
        u.push_back({4'b0, b[3:0], 2'b00});
        u.push_back({4'b0, b[7:4], 2'b00});
      end else begin
        u.push_back({b, 2'b00});
      end
    end
    while (u.size() < 4) u.push_back(10'h200);
    push(10'h000, "R2 flag0"); push(10'h3FF, "R2 flag1"); push(10'h3FF, "R2 flag2");
    push(10'h140, "R2 id"); push(sd, "R3 sdid"); push(dcw, "R4 dc");
    s = 7'(10'h140 >> 2) + sd[8:2] + dcw[8:2];
    for (int i = 0; i < u.size(); i++) begin
      s += u[i][8:2];
      push(u[i], (u[i] == 10'h200 && !split) ? "R7 pad" : (split ? "R6 nib" : "R5 byte"));
    end
    push({~s[6], s, 2'b00}, "R8 cksum", 1);
  endtask

  task automatic drive_start(input logic [31:0] raw, input bit four, input bit split,
                             input bit ef, input bit dbl, input logic [3:0] ln);
    raw_bytes = raw; four_bytes = four; split_nib = split;
    even_fld = ef; dbl_rate = dbl; line_code = ln; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(input logic [31:0] raw, input bit four, input bit split,
                      input bit ef, input bit dbl, input logic [3:0] ln);
    while (out_valid) @(negedge clk);
    build(raw, four, split, ef, dbl, ln);
    drive_start(raw, four, split, ef, dbl, ln);
  endtask

  task automatic drain();
    while (out_valid || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1 valid", {9'b0, out_valid}, 10'h0);
    chk(!done, "R1 done", {9'b0, done}, 10'h0);

    send(32'h01FF_3CA5, 1, 1, 1, 0, 4'hA); drain();
    send(32'h80C3_7E5A, 1, 0, 0, 1, 4'h3); drain();
    send(32'h0000_F00F, 0, 1, 1, 1, 4'hF); drain();
    send(32'h0000_9C81, 0, 0, 0, 0, 4'h0); drain();

    rdy_mode = 1;
    send(32'hDEAD_BEEF, 1, 1, 0, 1, 4'h7); drain();
    send(32'h1234_5678, 1, 0, 1, 0, 4'h9);
    send(32'h0000_FFFF, 0, 0, 1, 1, 4'h5); drain();

    // R10: start during a packet is dropped
    send(32'hCAFE_0102, 1, 0, 0, 0, 4'h2);
    repeat (4) @(negedge clk);
    drive_start(32'h5555_5555, 0, 1, 1, 1, 4'hC);
    drain();
    chk(!out_valid, "R10 no extra packet", {9'b0, out_valid}, 10'h0);

    // R12: start in the done cycle
    rdy_mode = 0;
    send(32'h0000_4321, 0, 1, 0, 1, 4'h1);
    while (!done) @(negedge clk);
    build(32'h0000_6789, 0, 0, 1, 0, 4'hE);
    drive_start(32'h0000_6789, 0, 0, 1, 0, 4'hE);
    chk(out_valid, "R12 accepted", {9'b0, out_valid}, 10'h1);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule